// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is a transmit-only I2C bus master. A host controls it through a small write port and reads its status as dedicated output flags. Setting the bus-busy control bit produces a start condition. The first byte the host then loads is the 7-bit target address plus the direction bit (0 for a write from master to target, 1 for a read). Every later byte is payload. Clearing the bus-busy bit produces a stop condition once the current byte has finished.

Data is double-buffered. A holding register accepts the next byte while the shift register is still sending the current one. When the shift register frees up, the held byte moves into it at once and the buffer reports empty again. Each byte is sent most significant bit first and is followed by a ninth clock. On that clock the target's acknowledge is captured. If no further byte is waiting when a byte ends, the block keeps SCL low until the host supplies data or asks for a stop. SCL and SDA are open-drain: the block only pulls a line low, and it reads both lines back.

The SCL rate comes from a prescaler of the system clock. A 4-bit clock-select field sets it, so one SCL period is `4 * (clk_sel + 1) * QUNIT` system clocks. SDA changes only in the middle of the SCL low phase, except when the block forms a start or a stop.

Top module: `i2c_mtx`

## Requirements
- R1: After reset, bus_busy=0, tx_empty=1, tx_end=0, ack_rx=0 and nack_flag=0, and neither SCL nor SDA is pulled low.
- R2: A write to address 0 with data bit 7 set, made while bus_busy=0, sets bus_busy on the next clock. It then produces a start condition: SDA falls while SCL is high. The same write while bus_busy=1 has no effect and produces no further start.
- R3: A write to address 0 with data bit 7 clear, made while bus_busy=1, requests a stop. Once the current byte ends, SDA rises while SCL is high. bus_busy returns to 0 only after both lines are sampled high. The same write while bus_busy=0 has no effect.
- R4: Each byte goes out most significant bit first as 8 data clocks. A ninth clock follows, during which the master releases SDA.
- R5: A write to address 1 loads the holding register and clears tx_empty. tx_empty is set again in the cycle after the byte moves into the shift register. A byte loaded before the current one's ninth clock ends starts one SCL period after the previous rising edge, with no hold in between.
- R6: tx_end is set at the ninth rising SCL edge if tx_empty=1 at that moment. Writing address 2 with bit 0 set clears tx_end; bit 1 of that write leaves tx_end alone.
- R7: ack_rx takes the SDA level at the ninth rising SCL edge, and nack_flag is set when that level is 1. Writing address 2 with bit 1 set clears nack_flag.
- R8: When a byte ends with no data pending and no stop requested, SCL stays low and no stop is produced.
- R9: The SCL period is 4*(clk_sel+1)*QUNIT clocks, where clk_sel is data bits 3:0 of the last write to address 0. SDA changes while SCL is high only to form a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host register address (0 control, 1 transmit data, 2 flag clear) |
| wr_data | input | 8 | Host write data |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| bus_busy | output | 1 | Bus owned by this master |
| tx_empty | output | 1 | Holding register can accept a byte |
| tx_end | output | 1 | Byte finished with nothing waiting |
| ack_rx | output | 1 | Acknowledge level sampled on the ninth clock |
| nack_flag | output | 1 | Sticky no-acknowledge indication |

## Verification
Any wrong shift count or phase counter shows up within one byte time. It appears as a mis-decoded byte at the target model, a rising-edge spacing other than four quarter ticks, or a spurious start or stop seen while SCL is high. A stuck buffer flag shows either as tx_empty never returning, or as an extra SCL hold between chained bytes, visible at the second byte's first edge. A corrupted busy or stop state shows as SCL rising during a hold, or as bus_busy dropping while SDA is still held low by the target model.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int BCNT_W  = $clog2(BYTE_W + 1);

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_TXD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd2;

  localparam int CTRL_BUSY_BIT = 7;
  localparam int CLR_END_BIT   = 0;
  localparam int CLR_NACK_BIT  = 1;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_START,
    ENG_HOLD,
    ENG_BIT,
    ENG_STOP,
    ENG_STOP_REL
  } eng_st_e;

endpackage

// File: rtl/i2c_mtx_prescale.sv
module i2c_mtx_prescale #(
  parameter int QUNIT = 2,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int CW = $clog2((2 ** SEL_W) * QUNIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;
  logic          wrap;

  assign limit = (CW'(sel) + CW'(1)) * CW'(QUNIT);
  assign wrap  = (cnt_q >= (limit - CW'(1)));
  assign tick  = run && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/i2c_mtx_regs.sv
module i2c_mtx_regs
  import i2c_mtx_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ld_evt,
  input  logic              rise9,
  input  logic              ack_smp,
  input  logic              stop_done,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              busy,
  output logic              start_go,
  output logic              stop_pend,
  output logic [BYTE_W-1:0] tdr,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              ack_rx,
  output logic              nack
);

  logic              wr_ctrl, wr_txd, wr_clr;
  logic [SEL_W-1:0]  sel_d;
  logic              busy_d, stop_d, empty_d, end_d, ack_d, nack_d;
  logic [BYTE_W-1:0] tdr_d;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_txd   = wr_en && (wr_addr == A_TXD);
  assign wr_clr   = wr_en && (wr_addr == A_CLR);
  assign start_go = wr_ctrl && wr_data[CTRL_BUSY_BIT] && !busy;

  always_comb begin
    sel_d   = clk_sel;
    busy_d  = busy;
    stop_d  = stop_pend;
    tdr_d   = tdr;
    empty_d = tx_empty;
    end_d   = tx_end;
    ack_d   = ack_rx;
    nack_d  = nack;

    if (wr_ctrl) begin
      sel_d = wr_data[SEL_W-1:0];
    end
    if (start_go) begin
      busy_d = 1'b1;
    end
    if (wr_ctrl && !wr_data[CTRL_BUSY_BIT] && busy) begin
      stop_d = 1'b1;
    end
    if (stop_done) begin
      busy_d = 1'b0;
      stop_d = 1'b0;
    end

    if (ld_evt) begin
      empty_d = 1'b1;
    end
    if (wr_txd) begin
      tdr_d   = wr_data;
      empty_d = 1'b0;
    end

    if (wr_clr && wr_data[CLR_END_BIT]) begin
      end_d = 1'b0;
    end
    if (wr_clr && wr_data[CLR_NACK_BIT]) begin
      nack_d = 1'b0;
    end
    if (rise9) begin
      ack_d = ack_smp;
      if (tx_empty) begin
        end_d = 1'b1;
      end
      if (ack_smp) begin
        nack_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel   <= '0;
      busy      <= 1'b0;
      stop_pend <= 1'b0;
      tdr       <= '0;
      tx_empty  <= 1'b1;
      tx_end    <= 1'b0;
      ack_rx    <= 1'b0;
      nack      <= 1'b0;
    end else begin
      clk_sel   <= sel_d;
      busy      <= busy_d;
      stop_pend <= stop_d;
      tdr       <= tdr_d;
      tx_empty  <= empty_d;
      tx_end    <= end_d;
      ack_rx    <= ack_d;
      nack      <= nack_d;
    end
  end

endmodule

// File: rtl/i2c_mtx_engine.sv
module i2c_mtx_engine
  import i2c_mtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_go,
  input  logic              stop_pend,
  input  logic              tdr_full,
  input  logic [BYTE_W-1:0] tdr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              ld_evt,
  output logic              rise9,
  output logic              stop_done,
  output logic              scl_oe,
  output logic              sda_oe
);

  localparam logic [BCNT_W-1:0] ACK_IDX = BCNT_W'(BYTE_W);

  eng_st_e           st_q, st_d;
  logic [1:0]        ph_q, ph_d;
  logic [BCNT_W-1:0] bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              scl_q, scl_d, sda_q, sda_d;
  logic              on_ack;

  assign on_ack = (bit_q == ACK_IDX);
  assign scl_oe = scl_q;
  assign sda_oe = sda_q;

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    scl_d     = scl_q;
    sda_d     = sda_q;
    ld_evt    = 1'b0;
    rise9     = 1'b0;
    stop_done = 1'b0;

    case (st_q)
      ENG_IDLE: begin
        scl_d = 1'b0;
        sda_d = 1'b0;
        if (start_go) begin
          st_d = ENG_START;
          ph_d = 2'd0;
        end
      end

      ENG_START: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          if (ph_q == 2'd1) begin
            sda_d = 1'b1;
          end
          if (ph_q == 2'd3) begin
            scl_d = 1'b1;
            st_d  = ENG_HOLD;
          end
        end
      end

      ENG_HOLD: begin
        if (tick) begin
          if (tdr_full) begin
            ld_evt = 1'b1;
            sh_d   = tdr;
            bit_d  = '0;
            ph_d   = 2'd0;
            st_d   = ENG_BIT;
          end else if (stop_pend) begin
            ph_d = 2'd0;
            st_d = ENG_STOP;
          end
        end
      end

      ENG_BIT: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_d = on_ack ? 1'b0 : !sh_q[BYTE_W-1];
            2'd1: begin
              scl_d = 1'b0;
              rise9 = on_ack;
            end
            2'd2: ;
            default: begin
              scl_d = 1'b1;
              if (!on_ack) begin
                bit_d = bit_q + BCNT_W'(1);
                sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              end else if (tdr_full) begin
                ld_evt = 1'b1;
                sh_d   = tdr;
                bit_d  = '0;
              end else begin
                st_d = ENG_HOLD;
              end
            end
          endcase
        end
      end

      ENG_STOP: begin
        if (tick) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd2: ;
            default: begin
              sda_d = 1'b0;
              st_d  = ENG_STOP_REL;
            end
          endcase
        end
      end

      ENG_STOP_REL: begin
        if (tick && scl_in && sda_in) begin
          stop_done = 1'b1;
          st_d      = ENG_IDLE;
        end
      end

      default: begin
        st_d  = ENG_IDLE;
        scl_d = 1'b0;
        sda_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      ph_q  <= 2'd0;
      bit_q <= '0;
      sh_q  <= '0;
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

endmodule

// File: rtl/i2c_mtx.sv
module i2c_mtx
  import i2c_mtx_pkg::*;
#(
  parameter int QUNIT = 2,
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              bus_busy,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              ack_rx,
  output logic              nack_flag
);

  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              tick, ld_evt, rise9, stop_done, start_go, stop_pend;
  logic [SEL_W-1:0]  clk_sel;
  logic [BYTE_W-1:0] tdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  i2c_mtx_prescale #(
    .QUNIT (QUNIT),
    .SEL_W (SEL_W)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_s),
    .run   (bus_busy),
    .sel   (clk_sel),
    .tick  (tick)
  );

  i2c_mtx_regs #(
    .SEL_W (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ld_evt    (ld_evt),
    .rise9     (rise9),
    .ack_smp   (sda_in),
    .stop_done (stop_done),
    .clk_sel   (clk_sel),
    .busy      (bus_busy),
    .start_go  (start_go),
    .stop_pend (stop_pend),
    .tdr       (tdr),
    .tx_empty  (tx_empty),
    .tx_end    (tx_end),
    .ack_rx    (ack_rx),
    .nack      (nack_flag)
  );

  i2c_mtx_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_s),
    .tick      (tick),
    .start_go  (start_go),
    .stop_pend (stop_pend),
    .tdr_full  (!tx_empty),
    .tdr       (tdr),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .ld_evt    (ld_evt),
    .rise9     (rise9),
    .stop_done (stop_done),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

endmodule

// File: rtl/i2c_mtx_chk.sv
module i2c_mtx_chk (
  input logic clk,
  input logic rst_s,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_in,
  input logic sda_in,
  input logic bus_busy,
  input logic tx_empty,
  input logic tx_end,
  input logic ack_rx,
  input logic nack_flag,
  input logic ld_evt
);

  // R5
  empty_reload_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(tx_empty) |-> $past(ld_evt));

  // R6
  end_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(tx_end) |-> (!scl_oe && $past(scl_oe)));

  // R7
  nack_level_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(nack_flag) |-> ack_rx);

  // R3
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(bus_busy) |-> $past(scl_in && sda_in));

  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(bus_busy) |-> (!scl_oe && !sda_oe));

endmodule

bind i2c_mtx i2c_mtx_chk u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .scl_in    (scl_in),
  .sda_in    (sda_in),
  .bus_busy  (bus_busy),
  .tx_empty  (tx_empty),
  .tx_end    (tx_end),
  .ack_rx    (ack_rx),
  .nack_flag (nack_flag),
  .ld_evt    (ld_evt)
);

// File: tb/i2c_mtx_tb.sv
module i2c_mtx_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       scl_in, sda_in, scl_oe, sda_oe;
  logic       bus_busy, tx_empty, tx_end, ack_rx, nack_flag;

  logic       ack_mode;
  logic       slv_ack;
  logic       slv_hold;

  int checks;
  int errors;
  logic done;

  assign scl_in = !scl_oe;
  assign sda_in = !sda_oe && !slv_ack && !slv_hold;

  i2c_mtx u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .bus_busy  (bus_busy),
    .tx_empty  (tx_empty),
    .tx_end    (tx_end),
    .ack_rx    (ack_rx),
    .nack_flag (nack_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Target model and line monitor
  int         cyc = 0;
  logic       p_scl = 1'b1;
  logic       p_sda = 1'b1;
  int         bitc = 0;
  int         nstart = 0;
  int         nstop = 0;
  int         nbytes = 0;
  int         last_rise = 0;
  int         last_gap = 0;
  int         first_gap = 0;
  logic       txend9 = 1'b0;
  logic [7:0] shv = 8'h00;
  logic [7:0] cap [0:15];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (scl_in && p_scl && p_sda && !sda_in) begin
        nstart = nstart + 1;
        bitc = 0;
      end
      if (scl_in && p_scl && !p_sda && sda_in) begin
        nstop = nstop + 1;
      end
      if (scl_in && !p_scl) begin
        bitc = bitc + 1;
        last_gap = cyc - last_rise;
        last_rise = cyc;
        if (bitc == 1) first_gap = last_gap;
        if (bitc <= 8) shv = {shv[6:0], sda_in};
        if (bitc == 9) txend9 = tx_end;
      end
      if (!scl_in && p_scl) begin
        if (bitc == 8) slv_ack = ack_mode;
        if (bitc == 9) begin
          slv_ack = 1'b0;
          if (nbytes < 16) cap[nbytes] = shv;
          nbytes = nbytes + 1;
          bitc = 0;
        end
      end
    end
    p_scl = scl_in;
    p_sda = sda_in;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic pick(input int which);
    case (which)
      0: pick = bus_busy;
      1: pick = tx_empty;
      default: pick = tx_end;
    endcase
  endfunction

  task automatic wait_until(input int which, input logic val, input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (pick(which) == val) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1", "bus_busy", int'(bus_busy), 0);
    chk("R1", "tx_empty", int'(tx_empty), 1);
    chk("R1", "tx_end", int'(tx_end), 0);
    chk("R1", "ack_rx", int'(ack_rx), 0);
    chk("R1", "nack_flag", int'(nack_flag), 0);
    chk("R1", "lines", int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic t_idle_stop();
    int s0, p0;
    s0 = nstart;
    p0 = nstop;
    host_wr(2'd0, 8'h00);
    repeat (30) @(negedge clk);
    chk("R3", "busy after idle stop write", int'(bus_busy), 0);
    chk("R3", "bus events after idle stop write", (nstart - s0) + (nstop - p0), 0);
    chk("R3", "lines after idle stop write", int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic t_chain();
    int s0, p0, b0, lowmiss;
    s0 = nstart;
    p0 = nstop;
    b0 = nbytes;
    ack_mode = 1'b1;
    host_wr(2'd0, 8'h80);
    chk("R2", "busy after start", int'(bus_busy), 1);
    repeat (10) @(negedge clk);
    chk("R2", "start seen", nstart - s0, 1);
    host_wr(2'd1, 8'hA4);
    chk("R5", "tx_empty after write", int'(tx_empty), 0);
    wait_until(1, 1'b1, 200);
    chk("R5", "tx_empty after move", int'(tx_empty), 1);
    host_wr(2'd1, 8'h5C);
    host_wr(2'd0, 8'h80);
    wait_until(2, 1'b1, 1000);
    repeat (6) @(negedge clk);
    chk("R2", "no second start while busy", nstart - s0, 1);
    chk("R4", "byte count", nbytes - b0, 2);
    chk("R4", "address byte", int'(cap[b0]), 'hA4);
    chk("R4", "data byte", int'(cap[b0 + 1]), 'h5C);
    chk("R5", "chained first edge gap", first_gap, 8);
    chk("R6", "tx_end at ninth rise", int'(txend9), 1);
    chk("R7", "ack_rx on ack", int'(ack_rx), 0);
    chk("R7", "nack on ack", int'(nack_flag), 0);
    lowmiss = 0;
    for (int i = 0; i < 40; i++) begin
      if (!scl_oe) lowmiss = lowmiss + 1;
      @(negedge clk);
    end
    chk("R8", "SCL released during hold", lowmiss, 0);
    chk("R8", "no stop during hold", nstop - p0, 0);
    host_wr(2'd2, 8'h01);
    chk("R6", "tx_end cleared", int'(tx_end), 0);
    host_wr(2'd0, 8'h00);
    wait_until(0, 1'b0, 500);
    chk("R3", "busy after stop", int'(bus_busy), 0);
    chk("R3", "stop seen", nstop - p0, 1);
    chk("R3", "lines released", int'({scl_oe, sda_oe}), 0);
    chk("R9", "only one start in transfer", nstart - s0, 1);
  endtask

  task automatic t_nack();
    int b0;
    b0 = nbytes;
    ack_mode = 1'b0;
    host_wr(2'd0, 8'h80);
    host_wr(2'd1, 8'h3B);
    wait_until(2, 1'b1, 1000);
    repeat (6) @(negedge clk);
    chk("R7", "ack_rx on nack", int'(ack_rx), 1);
    chk("R7", "nack_flag on nack", int'(nack_flag), 1);
    chk("R4", "nack byte", int'(cap[b0]), 'h3B);
    host_wr(2'd2, 8'h02);
    chk("R7", "nack cleared", int'(nack_flag), 0);
    chk("R6", "tx_end kept by nack clear", int'(tx_end), 1);
    host_wr(2'd2, 8'h01);
    host_wr(2'd0, 8'h00);
    wait_until(0, 1'b0, 500);
    chk("R3", "busy after nack stop", int'(bus_busy), 0);
  endtask

  task automatic t_slow_stuck();
    int b0, p0;
    b0 = nbytes;
    p0 = nstop;
    ack_mode = 1'b1;
    host_wr(2'd0, 8'h83);
    host_wr(2'd1, 8'hF0);
    wait_until(2, 1'b1, 3000);
    chk("R9", "SCL period clk_sel=3", last_gap, 32);
    repeat (20) @(negedge clk);
    chk("R4", "slow byte", int'(cap[b0]), 'hF0);
    slv_hold = 1'b1;
    host_wr(2'd2, 8'h01);
    host_wr(2'd0, 8'h03);
    repeat (300) @(negedge clk);
    chk("R3", "busy held while SDA low", int'(bus_busy), 1);
    chk("R3", "no stop while SDA low", nstop - p0, 0);
    slv_hold = 1'b0;
    wait_until(0, 1'b0, 100);
    chk("R3", "busy after SDA free", int'(bus_busy), 0);
    chk("R3", "stop after SDA free", nstop - p0, 1);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = 2'd0;
    wr_data  = 8'h00;
    ack_mode = 1'b1;
    slv_ack  = 1'b0;
    slv_hold = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_stop();
    t_chain();
    t_nack();
    t_slow_stuck();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule